// File: doc/BRIEF.md
# Packed SIMD Lane Shift Unit

This block shifts a 64-bit packed operand as four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Every lane moves by the same count and no bit crosses from one lane into the next. There are three shift operations: logical right, arithmetic right and logical left. A 3-bit operation field selects the operation. This field is the register-selector bits of a shift-group instruction. Codes with no shift behind them are reported as illegal, and the operand comes back unchanged.

The count is an unsigned byte. It is never reduced modulo the lane width. A logical shift by more than the lane width minus one clears the whole register. An arithmetic shift clamps the count to the lane width minus one, so each lane fills with its own sign bit. A one-bit latency select models the two count sources. A count from a register completes in one cycle and a count from memory takes two. The caller supplies the count byte itself, taking only the low byte of a wider register. Register-file access, fetch and exception delivery stay outside the block.

Top module: `simd_shift_unit`

## Requirements
- R1: `in_lane_sel` picks the lane layout: 0 gives four 16-bit lanes, 1 gives two 32-bit lanes, and 2 or 3 give one 64-bit lane. Each lane is shifted on its own, with no bits passed between lanes.
- R2: `in_op_field` value 2 is a logical right shift, value 4 is an arithmetic right shift and value 6 is a logical left shift. Vacated bits fill with zero for the logical shifts and with the lane's sign bit for the arithmetic shift, in every lane size including 64.
- R3: Any other `in_op_field` value (0, 1, 3, 5, 7) completes with `out_illegal` = 1 and `out_result` equal to the unmodified operand. A legal value completes with `out_illegal` = 0.
- R4: For logical left and logical right shifts, a count greater than the lane width minus one (up to 255) produces an all-zero 64-bit result. There is no modulo wrap.
- R5: For the arithmetic right shift, a count greater than the lane width minus one acts as width minus one, so every bit of each lane equals that lane's sign bit.
- R6: A count of zero returns the operand unchanged for all three operations and all lane sizes.
- R7: With `in_lat_sel` = 0, an accepted request raises `out_done` and presents its result right after the next rising edge. With `in_lat_sel` = 1 this happens one edge later, and `out_done` stays low in between.
- R8: While a two-cycle request is in flight, `in_valid` is ignored. No extra `out_done` pulse appears and the in-flight result is not disturbed.
- R9: After a synchronous active-low reset, `out_result` is 0, `out_done` is 0 and `out_illegal` is 0.
- R10: `out_done` is high for exactly one cycle per accepted request. `out_result` and `out_illegal` hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Packed operand |
| in_count | input | 8 | Unsigned shift count |
| in_lane_sel | input | 2 | Lane layout: 0=16-bit, 1=32-bit, 2/3=64-bit |
| in_op_field | input | 3 | Operation code: 2 logical right, 4 arithmetic right, 6 logical left |
| in_lat_sel | input | 1 | 0 = one-cycle completion, 1 = two-cycle completion |
| out_result | output | 64 | Registered shifted result |
| out_done | output | 1 | One-cycle completion pulse |
| out_illegal | output | 1 | Operation code had no shift behind it |

## Verification
The hardest situation to reach from the ports is a new request that arrives in the single cycle while a two-cycle operation is still pending. Directed stimulus creates it by driving a second, different request on the falling edge right after a slow request is accepted. The bench then checks that exactly one completion appears, that it carries the first request's data, and that the result holds afterwards. Both clamp boundaries (width minus one, width, 255) come from a full sweep of every count against every lane layout and every operation code. That sweep alternates the two latencies, so both paths carry every corner.

// File: rtl/simd_shift_pkg.sv
// Shared types and codes for the packed SIMD lane shift unit.
// Assumes a 3-bit operation field and a 2-bit lane layout select.
package simd_shift_pkg;

    // Decoded shift operation; SK_PASS marks a code with no shift behind it.
    typedef enum logic [1:0] {
        SK_PASS = 2'd0,
        SK_SRL  = 2'd1,
        SK_SRA  = 2'd2,
        SK_SLL  = 2'd3
    } shift_kind_e;

    // Operation field codes (the values are decoded by the instruction front end).
    localparam logic [2:0] OPC_SRL = 3'd2;
    localparam logic [2:0] OPC_SRA = 3'd4;
    localparam logic [2:0] OPC_SLL = 3'd6;

    // Lane layout select codes; bit 1 set selects the full-width lane.
    localparam logic [1:0] LSEL_16 = 2'd0;
    localparam logic [1:0] LSEL_32 = 2'd1;

    // Number of distinct lane layouts built in parallel.
    localparam int unsigned NUM_LAYOUTS = 3;

endpackage

// File: rtl/simd_shift_decode.sv
// Operation field decoder.
// Maps the 3-bit field onto a shift kind and flags codes with no shift.
// Assumes a purely combinational use; no state.
module simd_shift_decode
    import simd_shift_pkg::*;
(
    input  logic [2:0]  op_field,
    output shift_kind_e kind,
    output logic        bad_op
);

    // Purpose: translate the field into a kind, defaulting to pass-through.
    always_comb begin
        kind   = SK_PASS;
        bad_op = 1'b0;
        unique case (op_field)
            OPC_SRL: kind = SK_SRL;
            OPC_SRA: kind = SK_SRA;
            OPC_SLL: kind = SK_SLL;
            default: bad_op = 1'b1;
        endcase
    end

endmodule

// File: rtl/simd_lane_shifter.sv
// Fixed-layout lane shifter.
// Splits DATA_W into DATA_W/LANE_W lanes and shifts each one independently by
// the same unsigned count. Logical shifts past LANE_W-1 give zero lanes.
// Arithmetic shifts clamp the count to LANE_W-1.
// Assumes LANE_W is a power of two that divides DATA_W, and log2(LANE_W) <= CNT_W.
module simd_lane_shifter
    import simd_shift_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  shift_kind_e       kind,
    output logic [DATA_W-1:0] result
);

    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned SH_W  = $clog2(LANE_W);
    localparam logic [CNT_W-1:0] MAX_AMT = CNT_W'(LANE_W - 1);

    logic            over;
    logic [SH_W-1:0] amt;

    // Purpose: detect an oversize count and form the clamped shift amount.
    always_comb begin
        over = (count > MAX_AMT);
        amt  = over ? SH_W'(LANE_W - 1) : count[SH_W-1:0];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_in;
        logic [LANE_W-1:0] lane_out;

        assign lane_in = operand[l*LANE_W +: LANE_W];

        // Purpose: shift one lane according to the decoded kind.
        always_comb begin
            unique case (kind)
                SK_SRL:  lane_out = over ? '0 : (lane_in >> amt);
                SK_SRA:  lane_out = LANE_W'($signed(lane_in) >>> amt);
                SK_SLL:  lane_out = over ? '0 : (lane_in << amt);
                default: lane_out = lane_in;
            endcase
        end

        assign result[l*LANE_W +: LANE_W] = lane_out;
    end

endmodule

// File: rtl/simd_shift_datapath.sv
// Combinational shift datapath.
// Builds one lane shifter per layout (16, 32, 64-bit lanes) and selects the
// requested one. An illegal operation code passes the operand through.
// Assumes DATA_W is a multiple of 64 so every layout divides it.
module simd_shift_datapath
    import simd_shift_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CNT_W  = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        lane_sel,
    input  logic [2:0]        op_field,
    output logic [DATA_W-1:0] result,
    output logic              bad_op
);

    shift_kind_e       kind;
    logic [DATA_W-1:0] layout_res [NUM_LAYOUTS];

    simd_shift_decode u_dec (
        .op_field (op_field),
        .kind     (kind),
        .bad_op   (bad_op)
    );

    for (genvar g = 0; g < NUM_LAYOUTS; g++) begin : g_layout
        simd_lane_shifter #(
            .DATA_W (DATA_W),
            .LANE_W (16 << g),
            .CNT_W  (CNT_W)
        ) u_shf (
            .operand (operand),
            .count   (count),
            .kind    (kind),
            .result  (layout_res[g])
        );
    end

    // Purpose: pick the shifter output that matches the requested layout.
    always_comb begin
        unique case (lane_sel)
            LSEL_16: result = layout_res[0];
            LSEL_32: result = layout_res[1];
            default: result = layout_res[2];
        endcase
    end

endmodule

// File: rtl/simd_shift_unit.sv
// Packed SIMD lane shift unit, top level.
// Accepts a request when in_valid is high and no two-cycle request is pending.
// One-cycle requests register the result at the accepting edge. Two-cycle
// requests capture their inputs first and complete one edge later. A request
// offered while one is pending is dropped. One shared datapath serves both.
// Assumes a synchronous active-low reset.
module simd_shift_unit
    import simd_shift_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_operand,
    input  logic [7:0]        in_count,
    input  logic [1:0]        in_lane_sel,
    input  logic [2:0]        in_op_field,
    input  logic              in_lat_sel,
    output logic [63:0]       out_result,
    output logic              out_done,
    output logic              out_illegal
);

    logic              pend_q;
    logic [DATA_W-1:0] hold_operand_q;
    logic [CNT_W-1:0]  hold_count_q;
    logic [1:0]        hold_lane_q;
    logic [2:0]        hold_op_q;

    logic [DATA_W-1:0] dp_operand;
    logic [CNT_W-1:0]  dp_count;
    logic [1:0]        dp_lane;
    logic [2:0]        dp_op;
    logic [DATA_W-1:0] dp_result;
    logic              dp_bad;

    logic [DATA_W-1:0] result_q;
    logic              done_q;
    logic              illegal_q;

    // Purpose: feed the datapath from held inputs while a slow request is pending.
    always_comb begin
        if (pend_q) begin
            dp_operand = hold_operand_q;
            dp_count   = hold_count_q;
            dp_lane    = hold_lane_q;
            dp_op      = hold_op_q;
        end else begin
            dp_operand = DATA_W'(in_operand);
            dp_count   = CNT_W'(in_count);
            dp_lane    = in_lane_sel;
            dp_op      = in_op_field;
        end
    end

    simd_shift_datapath #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_dp (
        .operand  (dp_operand),
        .count    (dp_count),
        .lane_sel (dp_lane),
        .op_field (dp_op),
        .result   (dp_result),
        .bad_op   (dp_bad)
    );

    // Purpose: sequence acceptance, pending capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q         <= 1'b0;
            hold_operand_q <= '0;
            hold_count_q   <= '0;
            hold_lane_q    <= '0;
            hold_op_q      <= '0;
            result_q       <= '0;
            done_q         <= 1'b0;
            illegal_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (pend_q) begin
                result_q  <= dp_result;
                illegal_q <= dp_bad;
                done_q    <= 1'b1;
                pend_q    <= 1'b0;
            end else if (in_valid) begin
                if (in_lat_sel) begin
                    hold_operand_q <= DATA_W'(in_operand);
                    hold_count_q   <= CNT_W'(in_count);
                    hold_lane_q    <= in_lane_sel;
                    hold_op_q      <= in_op_field;
                    pend_q         <= 1'b1;
                end else begin
                    result_q  <= dp_result;
                    illegal_q <= dp_bad;
                    done_q    <= 1'b1;
                end
            end
        end
    end

    assign out_result  = result_q[63:0];
    assign out_done    = done_q;
    assign out_illegal = illegal_q;

endmodule

// File: rtl/simd_shift_unit_chk.sv
// Assertion checker for simd_shift_unit, attached by bind.
// Observes the ports and the pending flag; drives nothing.
module simd_shift_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_operand,
    input logic [7:0]  in_count,
    input logic [2:0]  in_op_field,
    input logic        in_lat_sel,
    input logic [63:0] out_result,
    input logic        out_done,
    input logic        out_illegal,
    input logic        pend_q
);

    logic accept_fast;
    logic code_ok;

    assign accept_fast = in_valid && !in_lat_sel && !pend_q;
    assign code_ok     = (in_op_field == 3'd2) || (in_op_field == 3'd4) ||
                         (in_op_field == 3'd6);

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_done && !out_illegal && out_result == 64'd0));

    // R7
    fast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_fast |=> out_done);

    // R8
    pend_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |=> (out_done && !pend_q));

    // R3
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_fast && !code_ok) |=> (out_illegal && out_result == $past(in_operand)));

    // R4
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_fast && (in_op_field == 3'd2 || in_op_field == 3'd6) && in_count >= 8'd64)
        |=> (out_result == 64'd0 && !out_illegal));

    // R6
    zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_fast && code_ok && in_count == 8'd0) |=> (out_result == $past(in_operand)));

    // R10
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_done && !$past(out_done)) |-> ($stable(out_result) && $stable(out_illegal)));

endmodule

bind simd_shift_unit simd_shift_unit_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_count    (in_count),
    .in_op_field (in_op_field),
    .in_lat_sel  (in_lat_sel),
    .out_result  (out_result),
    .out_done    (out_done),
    .out_illegal (out_illegal),
    .pend_q      (pend_q)
);

// File: tb/simd_shift_unit_tb.sv
module simd_shift_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [7:0]  in_count = '0;
    logic [1:0]  in_lane_sel = '0;
    logic [2:0]  in_op_field = '0;
    logic        in_lat_sel = 1'b0;
    logic [63:0] out_result;
    logic        out_done;
    logic        out_illegal;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_shift_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_count    (in_count),
        .in_lane_sel (in_lane_sel),
        .in_op_field (in_op_field),
        .in_lat_sel  (in_lat_sel),
        .out_result  (out_result),
        .out_done    (out_done),
        .out_illegal (out_illegal)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string tag, input logic ok,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Bit-level reference: each destination bit picks its source bit in its own lane.
    function automatic logic [63:0] ref_shift(input logic [63:0] x, input logic [2:0] op,
                                              input logic [1:0] ls, input int c);
        logic [63:0] r;
        int w;
        int cc;
        w = (ls == 2'd0) ? 16 : (ls == 2'd1) ? 32 : 64;
        r = x;
        if (op == 3'd2 || op == 3'd4 || op == 3'd6) begin
            for (int l = 0; l < 64 / w; l++) begin
                for (int b = 0; b < w; b++) begin
                    if (op == 3'd6)
                        r[l*w+b] = (c <= w - 1 && b - c >= 0) ? x[l*w+b-c] : 1'b0;
                    else if (op == 3'd2)
                        r[l*w+b] = (c <= w - 1 && b + c < w) ? x[l*w+b+c] : 1'b0;
                    else begin
                        cc = (c > w - 1) ? w - 1 : c;
                        r[l*w+b] = (b + cc < w) ? x[l*w+b+cc] : x[l*w+w-1];
                    end
                end
            end
        end
        return r;
    endfunction

    function automatic string tag_for(input logic [2:0] op, input logic [1:0] ls, input int c);
        int w;
        w = (ls == 2'd0) ? 16 : (ls == 2'd1) ? 32 : 64;
        if (!(op == 3'd2 || op == 3'd4 || op == 3'd6)) return "R3";
        if (c == 0) return "R6";
        if (c > w - 1) return (op == 3'd4) ? "R5" : "R4";
        return "R1 R2";
    endfunction

    // Drives one request at a falling edge and checks its completion.
    task automatic run_op(input logic [63:0] x, input logic [2:0] op, input logic [1:0] ls,
                          input int c, input logic lat);
        logic [63:0] exp;
        logic        exp_bad;
        string       tag;
        exp     = ref_shift(x, op, ls, c);
        exp_bad = !(op == 3'd2 || op == 3'd4 || op == 3'd6);
        tag     = tag_for(op, ls, c);
        in_valid    = 1'b1;
        in_operand  = x;
        in_count    = 8'(c);
        in_lane_sel = ls;
        in_op_field = op;
        in_lat_sel  = lat;
        @(negedge clk);
        in_valid = 1'b0;
        if (lat) begin
            check("R7 slow done low early", out_done == 1'b0, 64'(out_done), 64'd0);
            @(negedge clk);
        end
        check("R7 done", out_done == 1'b1, 64'(out_done), 64'd1);
        check(tag, out_result == exp, out_result, exp);
        check("R3 flag", out_illegal == exp_bad, 64'(out_illegal), 64'(exp_bad));
    endtask

    initial begin
        logic [63:0] pats [4];
        pats[0] = 64'h8001_7FFE_C3A5_0F0F;
        pats[1] = 64'hF0E1_D2C3_B4A5_9687;
        pats[2] = 64'h0123_4567_89AB_CDEF;
        pats[3] = 64'hFFFF_0000_8000_0001;

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 result", out_result == 64'd0, out_result, 64'd0);
        check("R9 done", out_done == 1'b0, 64'(out_done), 64'd0);
        check("R9 illegal", out_illegal == 1'b0, 64'(out_illegal), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep: lane layouts, op codes, every count, latency alternating.
        for (int ls = 0; ls < 4; ls++)
            for (int op = 0; op < 8; op++)
                for (int c = 0; c < 256; c++)
                    for (int p = 0; p < 3; p++)
                        run_op(pats[(p + c) % 4], 3'(op), 2'(ls), c, 1'((c + p) % 3 == 0));

        // R8 / R10: request offered during a pending slow request is dropped.
        in_valid = 1'b1; in_operand = 64'h1234_5678_9ABC_DEF0; in_count = 8'd4;
        in_lane_sel = 2'd0; in_op_field = 3'd6; in_lat_sel = 1'b1;
        @(negedge clk);
        in_operand = 64'hFFFF_FFFF_FFFF_FFFF; in_count = 8'd1; in_op_field = 3'd2;
        in_lat_sel = 1'b0;
        check("R8 no early done", out_done == 1'b0, 64'(out_done), 64'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 done", out_done == 1'b1, 64'(out_done), 64'd1);
        check("R8 result", out_result == 64'h2340_6780_ABC0_EF00, out_result,
              64'h2340_6780_ABC0_EF00);
        @(negedge clk);
        check("R10 single pulse", out_done == 1'b0, 64'(out_done), 64'd0);
        check("R10 hold", out_result == 64'h2340_6780_ABC0_EF00, out_result,
              64'h2340_6780_ABC0_EF00);
        @(negedge clk);
        check("R8 dropped request", out_done == 1'b0, 64'(out_done), 64'd0);

        // R10: illegal flag holds across idle cycles.
        run_op(64'hDEAD_BEEF_0000_1111, 3'd7, 2'd1, 3, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 illegal hold", out_illegal == 1'b1, 64'(out_illegal), 64'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule